// File: doc/BRIEF.md
# Synchronous Buck Gate Sequencer

This block is the per-cycle digital sequencer for the high-side and low-side switches of a synchronous buck converter. Each switching cycle begins on a one-clock start pulse. The sequencer first makes sure the low-side gate is confirmed off, then drives the high-side gate. It ends the high-side pulse when the PWM comparator trips or when over-current is flagged. It then waits for the switch node to fall below its threshold, or for a clock-count timeout, before it drives the low-side gate. The low-side gate stays on until the next cycle starts, unless the inductor current is about to reverse, in which case it turns off early.

A light-load mode skips pulses. The mode is allowed only while the active-low power-save pin is low. On entry the sequencer raises a regulation-offset request and runs that cycle as one extra pulse. While the mode is active, a cycle runs only if feedback is below reference; otherwise both gates stay low. The first cycle in which the light-load flag is clear leaves the mode.

All flags are taken as clean, synchronous, active-high inputs, except the power-save pin. The outputs are registered, one clock after the inputs that cause them.

Top module: `buck_gate_seq`

## Requirements
- R1: After reset, both gate outputs and the offset request are low.
- R2: The high-side gate turns on in the clock after a cycle start, provided the low-side-off feedback is high. It turns off one clock after the PWM trip input is seen high.
- R3: A cycle start turns the low-side gate off in the next clock. The high-side gate turns on only in a clock after the low-side-off feedback was high. The two gates are never high together.
- R4: Over-current seen while the high-side gate is on turns that gate off one clock later, with no PWM trip.
- R5: After the high-side turns off, the low-side gate turns on one clock after the phase-low flag is seen. Until then it stays off.
- R6: If the phase-low flag never arrives, the low-side gate turns on exactly PHASE_TMO clocks after the high-side gate went off.
- R7: A cycle start with the power-save pin low and light load high, while skip mode is inactive, sets the offset request one clock later. That cycle still produces a high-side pulse.
- R8: In skip mode, a cycle start with light load high and feedback-below-reference low is skipped. Both gates are low one clock later, and the high-side gate stays low until the next cycle start.
- R9: In skip mode, a cycle start with feedback-below-reference high runs normally, and the offset request stays high.
- R10: In skip mode, a cycle start with light load low clears the offset request and runs normally.
- R11: Current reversal seen while the low-side gate is on turns that gate off one clock later. It stays off until the next cycle.
- R12: While the power-save pin is high, skip mode cannot be entered, and the offset request clears one clock after the pin goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | One-clock pulse starting a switching cycle |
| pwm_trip | input | 1 | PWM comparator has reached the duty target |
| oc_flag | input | 1 | Over-current detected |
| phase_low | input | 1 | Switch node below threshold |
| ls_off_fb | input | 1 | Low-side gate sensed low |
| light_load | input | 1 | Load current below the light-load level |
| fb_low | input | 1 | Feedback below reference |
| i_rev | input | 1 | Inductor current about to reverse |
| psave_n | input | 1 | Power-save pin, low enables skip mode |
| hs_gate | output | 1 | High-side gate command |
| ls_gate | output | 1 | Low-side gate command |
| reg_boost | output | 1 | Regulation-point raise request |

## Verification
The in-RTL properties check the following on every cycle:
- the two gates never overlap;
- the interlock on high-side turn-on and low-side turn-on;
- over-current and reversal turn-offs;
- skipped cycles keep both gates low;
- offset request set on skip entry and cleared by the power-save pin.

Only the directed scenarios can show the rest:
- the exact timeout count;
- the high-side gate staying low for several clocks while feedback withholds permission;
- skip-mode exit on a heavy-load cycle;
- the sequence of gate levels across whole cycles.

// File: rtl/bgs_pkg.sv
package bgs_pkg;
   typedef enum logic [2:0] {
      GS_OFF     = 3'd0,
      GS_HS_WAIT = 3'd1,
      GS_HS_ON   = 3'd2,
      GS_DEAD    = 3'd3,
      GS_LS_ON   = 3'd4
   } gate_st_e;
endpackage

// File: rtl/bgs_skip_ctrl.sv
module bgs_skip_ctrl (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic light_load,
   input  logic fb_low,
   input  logic psave_n,
   output logic run_cycle,
   output logic skip_active
);
   logic skip_en;
   assign skip_en = ~psave_n;

   // A cycle is dropped only when already skipping, still light, and feedback is high enough
   assign run_cycle = ~(skip_active & skip_en & light_load & ~fb_low);

   always_ff @(posedge clk) begin
      if (!rst_n)
         skip_active <= 1'b0;
      else if (!skip_en)
         skip_active <= 1'b0;
      else if (cyc_start)
         skip_active <= light_load;
   end

   p_boost_entry_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !psave_n && light_load) |=> skip_active);
   p_boost_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
      psave_n |=> !skip_active);
endmodule

// File: rtl/bgs_ls_timer.sv
module bgs_ls_timer #(
   parameter int PHASE_TMO = 8,
   parameter bit USE_TMO   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic dead_active,
   output logic tmo_hit
);
   localparam int TW = (PHASE_TMO > 2) ? $clog2(PHASE_TMO) : 1;
   localparam logic [TW-1:0] LAST = TW'(PHASE_TMO - 1);

   generate
      if (PHASE_TMO < 2) begin : g_bad
         $error("PHASE_TMO must be at least 2");
      end
      if (USE_TMO) begin : g_tmo
         logic [TW-1:0] cnt;
         assign tmo_hit = dead_active & (cnt == LAST);
         always_ff @(posedge clk) begin
            if (!rst_n || !dead_active)
               cnt <= '0;
            else if (!tmo_hit)
               cnt <= cnt + 1'b1;
         end
      end else begin : g_no_tmo
         assign tmo_hit = 1'b0;
      end
   endgenerate

   p_hit_only_dead_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_hit |-> dead_active);
endmodule

// File: rtl/bgs_gate_fsm.sv
module bgs_gate_fsm
   import bgs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic run_cycle,
   input  logic pwm_trip,
   input  logic oc_flag,
   input  logic phase_low,
   input  logic tmo_hit,
   input  logic ls_off_fb,
   input  logic i_rev,
   output logic hs_gate,
   output logic ls_gate,
   output logic dead_active
);
   gate_st_e st;

   assign dead_active = (st == GS_DEAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st      <= GS_OFF;
         hs_gate <= 1'b0;
         ls_gate <= 1'b0;
      end else if (cyc_start) begin
         hs_gate <= 1'b0;
         ls_gate <= 1'b0;
         st      <= run_cycle ? GS_HS_WAIT : GS_OFF;
      end else begin
         unique case (st)
            GS_HS_WAIT: if (ls_off_fb) begin
               hs_gate <= 1'b1;
               st      <= GS_HS_ON;
            end
            GS_HS_ON: if (pwm_trip || oc_flag) begin
               hs_gate <= 1'b0;
               st      <= GS_DEAD;
            end
            GS_DEAD: if (phase_low || tmo_hit) begin
               ls_gate <= 1'b1;
               st      <= GS_LS_ON;
            end
            GS_LS_ON: if (i_rev) begin
               ls_gate <= 1'b0;
               st      <= GS_OFF;
            end
            default: st <= GS_OFF;
         endcase
      end
   end

   p_hs_needs_fb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_gate) |-> $past(ls_off_fb));
   p_ls_after_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ls_gate) |-> ($past(phase_low) || $past(tmo_hit)));
   p_oc_ends_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_gate && oc_flag) |=> !hs_gate);
   p_reverse_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (ls_gate && i_rev) |=> !ls_gate);
   p_trip_ends_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_gate && pwm_trip) |=> !hs_gate);
endmodule

// File: rtl/buck_gate_seq.sv
module buck_gate_seq #(
   parameter int PHASE_TMO = 8,
   parameter bit USE_TMO   = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cyc_start,
   input  logic pwm_trip,
   input  logic oc_flag,
   input  logic phase_low,
   input  logic ls_off_fb,
   input  logic light_load,
   input  logic fb_low,
   input  logic i_rev,
   input  logic psave_n,
   output logic hs_gate,
   output logic ls_gate,
   output logic reg_boost
);
   logic run_cycle;
   logic tmo_hit;
   logic dead_active;

   bgs_skip_ctrl u_skip (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_start  (cyc_start),
      .light_load (light_load),
      .fb_low     (fb_low),
      .psave_n    (psave_n),
      .run_cycle  (run_cycle),
      .skip_active(reg_boost)
   );

   bgs_ls_timer #(.PHASE_TMO(PHASE_TMO), .USE_TMO(USE_TMO)) u_tmr (
      .clk        (clk),
      .rst_n      (rst_n),
      .dead_active(dead_active),
      .tmo_hit    (tmo_hit)
   );

   bgs_gate_fsm u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .cyc_start  (cyc_start),
      .run_cycle  (run_cycle),
      .pwm_trip   (pwm_trip),
      .oc_flag    (oc_flag),
      .phase_low  (phase_low),
      .tmo_hit    (tmo_hit),
      .ls_off_fb  (ls_off_fb),
      .i_rev      (i_rev),
      .hs_gate    (hs_gate),
      .ls_gate    (ls_gate),
      .dead_active(dead_active)
   );

   p_no_overlap_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_gate && ls_gate));
   p_skip_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_start && !run_cycle) |=> (!hs_gate && !ls_gate));
   p_ls_off_on_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_start |=> !ls_gate);
endmodule

// File: tb/sim_buck_gate_seq.sv
module sim_buck_gate_seq;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cyc_start = 0, pwm_trip = 0, oc_flag = 0, phase_low = 0;
   logic ls_off_fb = 1, light_load = 0, fb_low = 0, i_rev = 0, psave_n = 1;
   logic hs_gate, ls_gate, reg_boost;
   int n_chk = 0, n_fail = 0;
   bit done = 0;

   localparam int TMO = 8;

   always #2.5 clk = ~clk;

   buck_gate_seq #(.PHASE_TMO(TMO), .USE_TMO(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .pwm_trip(pwm_trip),
      .oc_flag(oc_flag), .phase_low(phase_low), .ls_off_fb(ls_off_fb),
      .light_load(light_load), .fb_low(fb_low), .i_rev(i_rev),
      .psave_n(psave_n), .hs_gate(hs_gate), .ls_gate(ls_gate),
      .reg_boost(reg_boost)
   );

   task automatic chk(string req, string what, logic act, logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic begin_cycle();
      cyc_start = 1; tick(); cyc_start = 0;
   endtask

   task automatic full_cycle();
      begin_cycle(); tick();
      pwm_trip = 1; tick(); pwm_trip = 0;
      phase_low = 1; tick(); phase_low = 0;
   endtask

   task automatic t_reset();
      chk("R1", "hs", hs_gate, 0);
      chk("R1", "ls", ls_gate, 0);
      chk("R1", "boost", reg_boost, 0);
   endtask

   task automatic t_normal();
      begin_cycle();
      chk("R3", "ls off after start", ls_gate, 0);
      tick();
      chk("R2", "hs on", hs_gate, 1);
      chk("R3", "ls low with hs", ls_gate, 0);
      tick();
      chk("R2", "hs held", hs_gate, 1);
      pwm_trip = 1; tick(); pwm_trip = 0;
      chk("R2", "hs off on trip", hs_gate, 0);
      tick();
      chk("R5", "ls waits for phase", ls_gate, 0);
      phase_low = 1; tick(); phase_low = 0;
      chk("R5", "ls on after phase", ls_gate, 1);
      tick();
      chk("R5", "ls held", ls_gate, 1);
   endtask

   task automatic t_fb_wait();
      ls_off_fb = 0;
      begin_cycle();
      for (int i = 0; i < 3; i++) begin
         tick();
         chk("R3", "hs waits fb", hs_gate, 0);
      end
      ls_off_fb = 1; tick();
      chk("R3", "hs on after fb", hs_gate, 1);
      pwm_trip = 1; tick(); pwm_trip = 0;
      phase_low = 1; tick(); phase_low = 0;
   endtask

   task automatic t_oc();
      begin_cycle(); tick();
      chk("R4", "hs on", hs_gate, 1);
      oc_flag = 1; tick(); oc_flag = 0;
      chk("R4", "hs off on oc", hs_gate, 0);
      phase_low = 1; tick(); phase_low = 0;
   endtask

   task automatic t_timeout();
      begin_cycle(); tick();
      pwm_trip = 1; tick(); pwm_trip = 0;
      for (int i = 0; i < TMO - 1; i++) begin
         chk("R6", "ls before timeout", ls_gate, 0);
         tick();
      end
      chk("R6", "ls before timeout last", ls_gate, 0);
      tick();
      chk("R6", "ls on at timeout", ls_gate, 1);
   endtask

   task automatic t_reverse();
      full_cycle();
      chk("R11", "ls on", ls_gate, 1);
      i_rev = 1; tick(); i_rev = 0;
      chk("R11", "ls off on reversal", ls_gate, 0);
      tick(); tick();
      chk("R11", "ls stays off", ls_gate, 0);
   endtask

   task automatic t_skip();
      psave_n = 0; light_load = 1; fb_low = 0;
      begin_cycle();
      chk("R7", "boost on entry", reg_boost, 1);
      tick();
      chk("R7", "extra pulse", hs_gate, 1);
      pwm_trip = 1; tick(); pwm_trip = 0;
      phase_low = 1; tick(); phase_low = 0;
      begin_cycle();
      chk("R8", "skip hs low", hs_gate, 0);
      chk("R8", "skip ls low", ls_gate, 0);
      tick(); tick();
      chk("R8", "skip hs stays low", hs_gate, 0);
      fb_low = 1;
      begin_cycle(); fb_low = 0;
      tick();
      chk("R9", "runs on fb low", hs_gate, 1);
      chk("R9", "boost kept", reg_boost, 1);
      pwm_trip = 1; tick(); pwm_trip = 0;
      light_load = 0;
      begin_cycle();
      chk("R10", "boost cleared on exit", reg_boost, 0);
      tick();
      chk("R10", "runs on exit", hs_gate, 1);
      pwm_trip = 1; tick(); pwm_trip = 0;
   endtask

   task automatic t_psave_pin();
      psave_n = 1; light_load = 1; fb_low = 0;
      begin_cycle();
      chk("R12", "no boost with pin high", reg_boost, 0);
      tick();
      chk("R12", "cycle runs with pin high", hs_gate, 1);
      pwm_trip = 1; tick(); pwm_trip = 0;
      psave_n = 0;
      begin_cycle();
      chk("R7", "boost set", reg_boost, 1);
      psave_n = 1; tick();
      chk("R12", "boost cleared by pin", reg_boost, 0);
      light_load = 0;
   endtask

   initial begin
      repeat (4) tick();
      t_reset();
      rst_n = 1; tick();
      t_reset();
      t_normal();
      t_fb_wait();
      t_oc();
      t_timeout();
      t_reverse();
      t_skip();
      t_psave_pin();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule